// File: doc/BRIEF.md
# Claim/Complete Interrupt Register File

This block is the register side of a platform interrupt controller. It keeps a small priority value for each interrupt source, a pending bit and a claimed bit for each source, an enable word set and a threshold for each interrupt context, and it samples level-type source lines into the pending bits. Each context continuously selects its best eligible source. A source is eligible when it is pending, enabled for that context, not already claimed and above the context's threshold. The block drives one notification line per context while such a source exists.

Software reaches the state over a plain 32-bit register bus. The bus always accepts, and it returns read data one cycle after an accepted read. Reading a context's claim word hands out the winning source ID and moves that source from pending to claimed within the same access. Writing an ID to the same word ends the service of that source. Source ID 0 means "nothing" and never becomes pending.

Top module: `irq_claim_regs`

## Requirements
- R1: Only accesses with address bits [1:0] equal to 0 are decoded; a misaligned read returns 0 and a misaligned write changes nothing.
- R2: The priority of source n (1 to NSRC-1) is the word at PRIO_BASE + 4*(n-1); a write stores only the low PRIO_W bits (3 by default) and a read returns them zero-extended.
- R3: The pending vector is readable at PEND_BASE + 4*w, with source n at bit n%32 of word w = n/32; writes there are ignored.
- R4: Context c's enable word w sits at EN_BASE + c*EN_STRIDE + 4*w, with the bit layout of R3; only bits for existing sources are stored; word offsets w >= NWORDS read 0 and ignore writes.
- R5: Context c's threshold is the word at CTX_BASE + c*CTX_STRIDE; a write whose 32-bit value exceeds NUM_PRIO is dropped, values up to NUM_PRIO inclusive are stored.
- R6: A read of the word 4 bytes above the threshold (claim word) returns the eligible source with the highest priority, the lowest ID winning a tie, and 0 if none exists; a priority equal to the threshold is not eligible. A nonzero result clears that source's pending bit and sets its claimed bit in the same access, and this clear overrides any source-line change in that cycle.
- R7: A write of ID to the claim word clears that source's claimed bit only when the full 32-bit value is below NSRC; other values are ignored.
- R8: A source line going high sets its pending bit and going low clears it; a line held steady does not set the bit again after a claim has cleared it.
- R9: notify_o[c] is high exactly while context c has an eligible source, and it follows any change of priority, threshold, enable, pending or claimed state from the next cycle on.
- R10: After reset all priorities, thresholds, enables, pending and claimed bits are 0 and all notifications low; unmapped addresses read 0 and ignore writes.
- R11: bus_ready_o is always high; every accepted read gives rsp_valid_o high for exactly the next cycle with the data on rsp_rdata_o, and no response appears otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid_i | input | 1 | Access request |
| bus_ready_o | output | 1 | Access accepted (always high) |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata_o | output | 32 | Read data |
| src_i | input | NSRC-1 (indices NSRC-1..1) | Interrupt source levels |
| notify_o | output | NCTX | Per-context interrupt notification |

## Verification
A corrupted pending or claimed bit shows one cycle later as a wrong notify level, and at the next claim read as a wrong ID. A lost claimed bit reappears at once as a second notification for a source already handed out. The bench therefore checks notify_o after every state change and compares every claim return against a value derived from the priority and threshold rules, including ties and the equal-to-threshold boundary. Completion is tested with an out-of-range ID whose low bits alias a claimed source, so a truncated range check becomes visible when the next source edge raises notify_o.

// File: rtl/icc_pkg.sv
// Package: shared decode type for the claim/complete register file.
// Assumes: nothing beyond the bus and state definitions in the top module.
package icc_pkg;
    typedef enum logic [2:0] {
        RK_NONE,
        RK_PRIO,
        RK_PEND,
        RK_EN,
        RK_THR,
        RK_CLAIM
    } reg_kind_e;
endpackage

// File: rtl/icc_select.sv
// Module: icc_select
// Picks, for one context, the eligible source of highest priority above the
// threshold; on equal priority the lowest ID wins. Purely combinational.
// Assumes: elig_i already combines pending, enable and not-claimed; entry 0
// is the "no interrupt" ID and is never reported.
module icc_select #(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 3,
    localparam int ID_W  = $clog2(NSRC)
) (
    input  logic [NSRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [NSRC-1:0]             elig_i,
    input  logic [PRIO_W-1:0]           thr_i,
    output logic [ID_W-1:0]             id_o,
    output logic                        hit_o
);
    logic [PRIO_W-1:0] best_p;

    // Ascending scan with strict compare keeps the lowest ID on a tie.
    always_comb begin
        best_p = thr_i;
        id_o   = '0;
        hit_o  = 1'b0;
        for (int i = 1; i < NSRC; i++) begin
            if (elig_i[i] && (prio_i[i] > best_p)) begin
                best_p = prio_i[i];
                id_o   = ID_W'(i);
                hit_o  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/icc_srcstate.sv
// Module: icc_srcstate
// Holds the pending and claimed bit of every source and the last sampled
// source level. Pending follows level changes of the source line; a claim
// clear overrides a change in the same cycle.
// Assumes: at most one clear/set strobe per bit per cycle comes from the bus.
module icc_srcstate #(
    parameter int NSRC = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:1] src_i,
    input  logic [NSRC-1:1] clr_pend_i,
    input  logic [NSRC-1:1] set_clm_i,
    input  logic [NSRC-1:1] clr_clm_i,
    output logic [NSRC-1:0] pend_o,
    output logic [NSRC-1:0] clm_o
);
    logic [NSRC-1:1] src_q;
    logic [NSRC-1:1] pend_q;
    logic [NSRC-1:1] clm_q;

    // Per-source state update: level-change sampling, claim and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q  <= '0;
            pend_q <= '0;
            clm_q  <= '0;
        end else begin
            src_q <= src_i;
            for (int i = 1; i < NSRC; i++) begin
                if (clr_pend_i[i])
                    pend_q[i] <= 1'b0;
                else if (src_i[i] != src_q[i])
                    pend_q[i] <= src_i[i];
                if (set_clm_i[i])
                    clm_q[i] <= 1'b1;
                else if (clr_clm_i[i])
                    clm_q[i] <= 1'b0;
            end
        end
    end

    assign pend_o = {pend_q, 1'b0};
    assign clm_o  = {clm_q, 1'b0};

    for (genvar g = 1; g < NSRC; g++) begin : g_chk
        AST_CLAIM_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
            clr_pend_i[g] |=> !pend_q[g] && clm_q[g]); // R6
        AST_COMPLETE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_clm_i[g] && !set_clm_i[g]) |=> !clm_q[g]); // R7
        AST_RISE_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
            (src_i[g] && !src_q[g] && !clr_pend_i[g]) |=> pend_q[g]); // R8
    end
endmodule

// File: rtl/irq_claim_regs.sv
// Module: irq_claim_regs (top)
// Register file of an interrupt controller: source priorities, pending and
// claimed vectors, per-context enables and thresholds, claim-on-read and
// complete-on-write. Drives one notify line per context.
// Assumes: EN_STRIDE and CTX_STRIDE are powers of two, the regions do not
// overlap, and the bus master accepts read data one cycle after the read.
module irq_claim_regs #(
    parameter int          NSRC       = 8,
    parameter int          NCTX       = 2,
    parameter int          NUM_PRIO   = 7,
    parameter int          ADDR_W     = 16,
    parameter logic [31:0] PRIO_BASE  = 32'h0000,
    parameter logic [31:0] PEND_BASE  = 32'h1000,
    parameter logic [31:0] EN_BASE    = 32'h2000,
    parameter int          EN_STRIDE  = 32'h80,
    parameter logic [31:0] CTX_BASE   = 32'h4000,
    parameter int          CTX_STRIDE = 32'h100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid_i,
    output logic              bus_ready_o,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic              rsp_valid_o,
    output logic [31:0]       rsp_rdata_o,
    input  logic [NSRC-1:1]   src_i,
    output logic [NCTX-1:0]   notify_o
);
    import icc_pkg::*;

    localparam int PRIO_W = $clog2(NUM_PRIO + 1);
    localparam int ID_W   = $clog2(NSRC);
    localparam int NWORDS = (NSRC + 31) / 32;
    localparam int EN_SH  = $clog2(EN_STRIDE);
    localparam int CTX_SH = $clog2(CTX_STRIDE);

    // State
    logic [NSRC-1:1][PRIO_W-1:0] prio_q;
    logic [NCTX-1:0][NSRC-1:0]   en_q;
    logic [NCTX-1:0][PRIO_W-1:0] thr_q;
    logic                        rsp_valid_q;
    logic [31:0]                 rsp_data_q;

    // Derived views
    logic [NSRC-1:0][PRIO_W-1:0]       prio_all;
    logic [NSRC-1:0]                   pend_all, clm_all;
    logic [NWORDS-1:0][31:0]           pend_w;
    logic [NCTX-1:0][NWORDS-1:0][31:0] en_w;
    logic [NCTX-1:0][ID_W-1:0]         win_id;
    logic [NCTX-1:0]                   win_hit;

    // Decode
    reg_kind_e   reg_kind;
    int unsigned sel_src, sel_ctx, sel_word;
    logic [31:0] a32, off;
    logic        acc_rd, acc_wr;
    logic [31:0] rd_data;
    logic [ID_W-1:0] claim_id;
    logic        claim_fire;
    logic [NSRC-1:1] clr_pend, set_clm, clr_clm;

    assign bus_ready_o = 1'b1;
    assign acc_rd      = bus_valid_i && !bus_write_i;
    assign acc_wr      = bus_valid_i && bus_write_i;

    // Address decode into register kind, context, source and word.
    always_comb begin
        reg_kind = RK_NONE;
        sel_src  = 0;
        sel_ctx  = 0;
        sel_word = 0;
        off      = '0;
        a32      = 32'(bus_addr_i);
        if (a32[1:0] == 2'b00) begin
            if (a32 >= PRIO_BASE && a32 < PRIO_BASE + 32'(4 * (NSRC - 1))) begin
                off      = a32 - PRIO_BASE;
                reg_kind = RK_PRIO;
                sel_src  = (off >> 2) + 1;
            end else if (a32 >= PEND_BASE && a32 < PEND_BASE + 32'(4 * NWORDS)) begin
                off      = a32 - PEND_BASE;
                reg_kind = RK_PEND;
                sel_word = off >> 2;
            end else if (a32 >= EN_BASE && a32 < EN_BASE + 32'(NCTX * EN_STRIDE)) begin
                off      = a32 - EN_BASE;
                sel_ctx  = off >> EN_SH;
                sel_word = (off & 32'(EN_STRIDE - 1)) >> 2;
                if (sel_word < NWORDS) reg_kind = RK_EN;
            end else if (a32 >= CTX_BASE && a32 < CTX_BASE + 32'(NCTX * CTX_STRIDE)) begin
                off     = a32 - CTX_BASE;
                sel_ctx = off >> CTX_SH;
                if ((off & 32'(CTX_STRIDE - 1)) == 32'd0)      reg_kind = RK_THR;
                else if ((off & 32'(CTX_STRIDE - 1)) == 32'd4) reg_kind = RK_CLAIM;
            end
        end
    end

    // Padded word views of priorities, pending and enable vectors.
    always_comb begin
        prio_all[0] = '0;
        for (int i = 1; i < NSRC; i++) prio_all[i] = prio_q[i];
        pend_w = (NWORDS * 32)'(pend_all);
        for (int c = 0; c < NCTX; c++) en_w[c] = (NWORDS * 32)'(en_q[c]);
    end

    // One selector per context.
    for (genvar c = 0; c < NCTX; c++) begin : g_ctx
        icc_select #(.NSRC(NSRC), .PRIO_W(PRIO_W)) u_sel (
            .prio_i (prio_all),
            .elig_i (pend_all & ~clm_all & en_q[c]),
            .thr_i  (thr_q[c]),
            .id_o   (win_id[c]),
            .hit_o  (win_hit[c])
        );
        assign notify_o[c] = win_hit[c];

        AST_NOTIFY_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_n)
            notify_o[c] |-> (prio_all[win_id[c]] > thr_q[c]) && en_q[c][win_id[c]]); // R9
    end

    // Read data mux and claim winner of the addressed context.
    always_comb begin
        rd_data  = '0;
        claim_id = '0;
        for (int c = 0; c < NCTX; c++)
            if (sel_ctx == c) claim_id = win_id[c];
        case (reg_kind)
            RK_PRIO:  for (int i = 1; i < NSRC; i++)
                          if (sel_src == i) rd_data = 32'(prio_q[i]);
            RK_PEND:  for (int w = 0; w < NWORDS; w++)
                          if (sel_word == w) rd_data = pend_w[w];
            RK_EN:    for (int c = 0; c < NCTX; c++)
                          for (int w = 0; w < NWORDS; w++)
                              if (sel_ctx == c && sel_word == w) rd_data = en_w[c][w];
            RK_THR:   for (int c = 0; c < NCTX; c++)
                          if (sel_ctx == c) rd_data = 32'(thr_q[c]);
            RK_CLAIM: rd_data = 32'(claim_id);
            default:  rd_data = '0;
        endcase
    end

    assign claim_fire = acc_rd && (reg_kind == RK_CLAIM) && (claim_id != '0);

    // One-hot strobes for claim (pending clear, claimed set) and completion.
    always_comb begin
        for (int i = 1; i < NSRC; i++) begin
            clr_pend[i] = claim_fire && (claim_id == ID_W'(i));
            set_clm[i]  = clr_pend[i];
            clr_clm[i]  = acc_wr && (reg_kind == RK_CLAIM) && (bus_wdata_i == 32'(i));
        end
    end

    icc_srcstate #(.NSRC(NSRC)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_i),
        .clr_pend_i (clr_pend),
        .set_clm_i  (set_clm),
        .clr_clm_i  (clr_clm),
        .pend_o     (pend_all),
        .clm_o      (clm_all)
    );

    // Writable configuration: priorities, enables, thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (acc_wr) begin
            for (int i = 1; i < NSRC; i++)
                if (reg_kind == RK_PRIO && sel_src == i) prio_q[i] <= bus_wdata_i[PRIO_W-1:0];
            for (int c = 0; c < NCTX; c++) begin
                for (int i = 0; i < NSRC; i++)
                    if (reg_kind == RK_EN && sel_ctx == c && sel_word == i / 32)
                        en_q[c][i] <= bus_wdata_i[i % 32];
                if (reg_kind == RK_THR && sel_ctx == c && bus_wdata_i <= 32'(NUM_PRIO))
                    thr_q[c] <= bus_wdata_i[PRIO_W-1:0];
            end
        end
    end

    // Read response register: valid and data one cycle after the read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            rsp_valid_q <= acc_rd;
            if (acc_rd) rsp_data_q <= rd_data;
        end
    end

    assign rsp_valid_o = rsp_valid_q;
    assign rsp_rdata_o = rsp_data_q;

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rd |=> rsp_valid_o); // R11
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_rd |=> !rsp_valid_o); // R11
    AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && bus_addr_i[1:0] != 2'b00) |=> rsp_rdata_o == 32'd0); // R1
    AST_CLAIM_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        claim_fire |=> clm_all[$past(claim_id)] && !pend_all[$past(claim_id)]); // R6
    AST_THR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_wr && reg_kind == RK_THR && bus_wdata_i > 32'(NUM_PRIO)) |=> $stable(thr_q)); // R5
endmodule

// File: tb/tb_irq_claim_regs.sv
module tb_irq_claim_regs;
    localparam int NSRC = 8;
    localparam int NCTX = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_ready;
    logic              bus_write = 1'b0;
    logic [15:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_rdata;
    logic [NSRC-1:1]   src = '0;
    logic [NCTX-1:0]   notify;

    int checks = 0;
    int failures = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;   // 125 MHz

    irq_claim_regs dut (
        .clk(clk), .rst_n(rst_n),
        .bus_valid_i(bus_valid), .bus_ready_o(bus_ready),
        .bus_write_i(bus_write), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
        .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
        .src_i(src), .notify_o(notify)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Monitor: every response pops the oldest expected read value.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected response", rsp_rdata, 32'd0);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rsp_rdata === e, t, rsp_rdata, e);
            end
        end
    end

    // Driver tasks start and end at a falling edge.
    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e); tag_q.push_back(t);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic set_src(input int n, input logic v);
        src[n] = v;
        @(negedge clk);
    endtask

    task automatic chk_notify(input logic [1:0] e, input string t);
        check(notify === e, t, 32'(notify), 32'(e));
    endtask

    initial begin
        #(8 * 20000);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state, R11 idle bus
        chk_notify(2'b00, "R10 notify after reset");
        check(bus_ready === 1'b1, "R11 ready", 32'(bus_ready), 32'd1);
        check(rsp_valid === 1'b0, "R11 idle rsp", 32'(rsp_valid), 32'd0);
        rd(16'h0008, 32'd0, "R10 prio reset");
        rd(16'h1000, 32'd0, "R10 pending reset");
        rd(16'h4000, 32'd0, "R10 threshold reset");
        rd(16'h4004, 32'd0, "R6 empty claim");

        // R2 priority storage
        wr(16'h0000, 32'hFFFF_FFF5);
        rd(16'h0000, 32'd5, "R2 prio low bits");
        // R1 misaligned
        wr(16'h0001, 32'd2);
        rd(16'h0000, 32'd5, "R1 misaligned write ignored");
        rd(16'h0002, 32'd0, "R1 misaligned read zero");
        // R10 unmapped
        wr(16'h0800, 32'h1234);
        rd(16'h0800, 32'd0, "R10 unmapped read");

        // R4 enables
        wr(16'h2000, 32'hFFFF_FFAA);
        rd(16'h2000, 32'hAA, "R4 enable stored bits");
        wr(16'h2004, 32'h55);
        rd(16'h2004, 32'd0, "R4 word beyond range");
        rd(16'h2080, 32'd0, "R4 context separation");

        // R5 thresholds
        wr(16'h4000, 32'd2);
        rd(16'h4000, 32'd2, "R5 threshold write");
        wr(16'h4000, 32'd9);
        rd(16'h4000, 32'd2, "R5 threshold too large dropped");
        wr(16'h4000, 32'd7);
        rd(16'h4000, 32'd7, "R5 threshold at limit");
        wr(16'h4000, 32'd2);

        wr(16'h0008, 32'd4);   // src3
        wr(16'h0010, 32'd4);   // src5
        wr(16'h0018, 32'd3);   // src7

        // R8 source edges, R9 notify
        src[3] = 1'b1; src[5] = 1'b1;
        @(negedge clk);
        chk_notify(2'b01, "R9 notify ctx0 only");
        wr(16'h1000, 32'd0);
        rd(16'h1000, 32'h28, "R3 pending read-only");

        // R6 claim with tie -> lowest ID
        rd(16'h4004, 32'd3, "R6 tie lowest id");
        rd(16'h1000, 32'h20, "R8 held level no re-pend");
        rd(16'h4004, 32'd5, "R6 second claim");
        chk_notify(2'b00, "R9 notify drops after claims");
        rd(16'h4004, 32'd0, "R6 nothing left");

        // R7 completion range check
        wr(16'h4004, 32'd13);
        set_src(5, 1'b0);
        set_src(5, 1'b1);
        chk_notify(2'b00, "R7 out-of-range complete ignored");
        wr(16'h4004, 32'd5);
        chk_notify(2'b01, "R7 complete re-arms source");
        rd(16'h4004, 32'd5, "R6 claim after complete");
        wr(16'h4004, 32'd5);
        wr(16'h4004, 32'd3);
        chk_notify(2'b00, "R8 no pending after completes");

        // R6 threshold boundary
        wr(16'h4000, 32'd3);
        set_src(7, 1'b1);
        chk_notify(2'b00, "R6 prio equal threshold not eligible");
        rd(16'h4004, 32'd0, "R6 equal threshold claim empty");
        wr(16'h4000, 32'd2);
        chk_notify(2'b01, "R9 threshold lowered");
        rd(16'h4004, 32'd7, "R6 claim src7");

        // Shared claimed state across contexts
        wr(16'h2080, 32'h02);
        set_src(1, 1'b1);
        chk_notify(2'b11, "R9 both contexts");
        rd(16'h4104, 32'd1, "R6 claim from ctx1");
        chk_notify(2'b00, "R9 claim clears both");
        wr(16'h4104, 32'd1);
        set_src(1, 1'b0);
        set_src(1, 1'b1);
        chk_notify(2'b11, "R8 new edge pends");
        wr(16'h0000, 32'd0);
        chk_notify(2'b00, "R9 priority change");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R11 all reads answered", 32'(exp_q.size()), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule